// File: doc/BRIEF.md
# Shared and Dedicated Credit Tracker

This block does the transmit-side credit bookkeeping for a link that carries several virtual channels. Each channel has three credit types: posted, non-posted and completion. Every channel owns a private dedicated pool for each type. All channels also share one common pool per type. The link partner advertises credits, and each advertisement names a channel, a type, whether it is dedicated or shared, and a value. The tracker builds its pools from these advertisements. The transmit path then asks it for permission to send a packet that needs a given number of credits. Credits that the receiver frees come back as returns, and each return is tagged with the pool it belongs to.

Each channel accepts its advertisements through a small state machine with seven states. In order they are ST_DED_P, ST_DED_NP, ST_DED_CPL, ST_SHR_P, ST_SHR_NP, ST_SHR_CPL and ST_READY. The only transition is to advance to the next state, and it happens when the advertisement matching the current state arrives. Any other advertisement leaves the state unchanged. ST_READY is terminal until reset.

Channel 0 goes through this sequence first, and its shared advertisements set the starting size of each shared pool. Channels enabled later add their shared advertisements to those pools. A request is served from the channel's dedicated pool if that pool holds enough credits. If it does not, the request is served from the shared pool of that type if the shared pool holds enough. If neither pool holds enough, the request stalls and the requester retries.

Top module: `credit_pool_tracker`

## Requirements
- R1: After reset no channel is initialized, `gnt` is 0, and no request is granted until a channel reaches ST_READY.
- R2: A channel accepts advertisements only in this order: dedicated posted, dedicated non-posted, dedicated completion, then shared posted, shared non-posted, shared completion. Type codes are 0 for posted, 1 for non-posted and 2 for completion. On `adv_ded`, 1 means dedicated and 0 means shared. An advertisement that is out of order, or that arrives after ST_READY, is ignored.
- R3: While channel 0 is not in ST_READY, every advertisement to any other channel is ignored.
- R4: A request to a channel that is not in ST_READY is never granted.
- R5: A request is granted from the dedicated pool (`gnt_ded`=1) when that pool holds at least `req_amt` credits. The pool is then reduced by `req_amt`.
- R6: Otherwise, the request is granted from the shared pool of its type (`gnt_ded`=0) when that pool holds at least `req_amt` credits. If the shared pool does not hold enough either, `gnt` is 0 and no pool is charged.
- R7: Each shared pool starts at channel 0's shared advertisement for that type. Every later channel's shared advertisement for that type is added to both the pool and its limit. A zero contribution is accepted and adds nothing.
- R8: A channel may advertise zero dedicated credits. All of its traffic for that type is then granted from the shared pool.
- R9: If channel 0 advertises zero shared credits for a type, the shared pool for that type becomes infinite: requests that fall back to it are always granted and nothing is charged to it.
- R10: A credit return adds `ret_amt` to the pool chosen by `ret_ded`, `ret_vc` and `ret_type`. The result saturates at that pool's total advertised value.
- R11: `gnt` and `gnt_ded` are registered one clock after the request is sampled. The decision uses the pool contents before that clock edge, so a return in the same cycle can only serve later requests.
- R12: Type code 3 is not a valid type. An advertisement of type 3 is ignored, and a request of type 3 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_valid | input | 1 | Credit advertisement present |
| adv_vc | input | VC_W | Channel of the advertisement |
| adv_type | input | 2 | Credit type of the advertisement (0 posted, 1 non-posted, 2 completion) |
| adv_ded | input | 1 | 1 = dedicated advertisement, 0 = shared advertisement |
| adv_value | input | CRED_W | Advertised credit count |
| req_valid | input | 1 | Transmit request present |
| req_vc | input | VC_W | Channel of the request |
| req_type | input | 2 | Credit type of the request |
| req_amt | input | CRED_W | Credits the packet needs |
| ret_valid | input | 1 | Credit return present |
| ret_vc | input | VC_W | Channel of the return (applies to dedicated returns) |
| ret_type | input | 2 | Credit type of the return |
| ret_ded | input | 1 | 1 = return to the dedicated pool, 0 = return to the shared pool |
| ret_amt | input | CRED_W | Credits returned |
| gnt | output | 1 | Request from the previous cycle was granted |
| gnt_ded | output | 1 | Grant was charged to the dedicated pool (1) or to the shared pool (0) |

## Verification
A request and a credit return can land on the same dedicated pool in the same cycle. To provoke this, the bench first drains the dedicated posted pool of channel 0 to zero. It then drives a one-credit request together with a one-credit dedicated return in a single cycle. That grant must come from the shared pool, and a one-credit request in the following cycle must come from the dedicated pool. Saturation is judged the same way: after an oversized return, a request one credit larger than the advertised limit must not be served from the dedicated pool.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

    localparam int NUM_TYPES = 3;

    typedef enum logic [1:0] {
        CT_POST    = 2'd0,
        CT_NONPOST = 2'd1,
        CT_CMPL    = 2'd2
    } ctype_e;

    typedef enum logic [2:0] {
        ST_DED_P,
        ST_DED_NP,
        ST_DED_CPL,
        ST_SHR_P,
        ST_SHR_NP,
        ST_SHR_CPL,
        ST_READY
    } init_st_e;

endpackage

// File: rtl/cpt_pool.sv
module cpt_pool #(
    parameter  int CRED_W = 10,
    localparam int EW     = CRED_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_en,
    input  logic [CRED_W-1:0] adv_val,
    input  logic              take_en,
    input  logic [CRED_W-1:0] take_amt,
    input  logic              give_en,
    input  logic [CRED_W-1:0] give_amt,
    output logic [CRED_W-1:0] cnt,
    output logic [CRED_W-1:0] lim
);

    localparam logic [EW-1:0] CAP = EW'({CRED_W{1'b1}});

    logic [EW-1:0]     lim_sum;
    logic [EW-1:0]     cnt_sum;
    logic [CRED_W-1:0] lim_d;
    logic [CRED_W-1:0] cnt_d;

    // Limit grows with each accepted advertisement; the count is charged,
    // credited and clipped to the new limit in one step.
    always_comb begin
        lim_sum = EW'(lim) + (adv_en ? EW'(adv_val) : '0);
        lim_d   = (lim_sum > CAP) ? CAP[CRED_W-1:0] : lim_sum[CRED_W-1:0];
        cnt_sum = EW'(cnt)
                - (take_en ? EW'(take_amt) : '0)
                + (adv_en  ? EW'(adv_val)  : '0)
                + (give_en ? EW'(give_amt) : '0);
        cnt_d   = (cnt_sum > EW'(lim_d)) ? lim_d : cnt_sum[CRED_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            lim <= '0;
        end else begin
            cnt <= cnt_d;
            lim <= lim_d;
        end
    end

endmodule

// File: rtl/cpt_vc_init.sv
module cpt_vc_init
    import cpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_hit,
    input  logic [1:0] adv_type,
    input  logic       adv_ded,
    input  logic       allowed,
    output logic       accept,
    output logic       ready
);

    init_st_e st_q, st_d, st_nxt;
    logic     exp_ded;
    ctype_e   exp_type;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_DED_P;
        else        st_q <= st_d;
    end

    always_comb begin
        exp_ded  = 1'b1;
        exp_type = CT_POST;
        ready    = 1'b0;
        st_nxt   = st_q;
        unique case (st_q)
            ST_DED_P:   begin exp_ded = 1'b1; exp_type = CT_POST;    st_nxt = ST_DED_NP;  end
            ST_DED_NP:  begin exp_ded = 1'b1; exp_type = CT_NONPOST; st_nxt = ST_DED_CPL; end
            ST_DED_CPL: begin exp_ded = 1'b1; exp_type = CT_CMPL;    st_nxt = ST_SHR_P;   end
            ST_SHR_P:   begin exp_ded = 1'b0; exp_type = CT_POST;    st_nxt = ST_SHR_NP;  end
            ST_SHR_NP:  begin exp_ded = 1'b0; exp_type = CT_NONPOST; st_nxt = ST_SHR_CPL; end
            ST_SHR_CPL: begin exp_ded = 1'b0; exp_type = CT_CMPL;    st_nxt = ST_READY;   end
            ST_READY:   begin ready = 1'b1; end
            default:    begin st_nxt = ST_DED_P; end
        endcase
        accept = adv_hit && allowed && !ready
              && (adv_ded == exp_ded) && (adv_type == exp_type);
        st_d   = accept ? st_nxt : st_q;
    end

endmodule

// File: rtl/credit_pool_tracker.sv
module credit_pool_tracker
    import cpt_pkg::*;
#(
    parameter  int NUM_VC = 4,
    parameter  int CRED_W = 10,
    localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_valid,
    input  logic [VC_W-1:0]   adv_vc,
    input  logic [1:0]        adv_type,
    input  logic              adv_ded,
    input  logic [CRED_W-1:0] adv_value,
    input  logic              req_valid,
    input  logic [VC_W-1:0]   req_vc,
    input  logic [1:0]        req_type,
    input  logic [CRED_W-1:0] req_amt,
    input  logic              ret_valid,
    input  logic [VC_W-1:0]   ret_vc,
    input  logic [1:0]        ret_type,
    input  logic              ret_ded,
    input  logic [CRED_W-1:0] ret_amt,
    output logic              gnt,
    output logic              gnt_ded
);

    logic [NUM_VC-1:0]                              vc_rdy;
    logic [NUM_VC-1:0]                              vc_acc;
    logic [NUM_VC-1:0][NUM_TYPES-1:0][CRED_W-1:0]   ded_cnt;
    logic [NUM_VC-1:0][NUM_TYPES-1:0][CRED_W-1:0]   ded_lim;
    logic [NUM_TYPES-1:0][CRED_W-1:0]               shr_cnt;
    logic [NUM_TYPES-1:0][CRED_W-1:0]               shr_lim;
    logic [NUM_TYPES-1:0]                           inf_q;

    logic [VC_W-1:0]   vi;
    logic [1:0]        ti;
    logic              req_vc_rdy;
    logic              req_ok;
    logic [CRED_W-1:0] ded_avail;
    logic [CRED_W-1:0] shr_avail;
    logic              ded_ok;
    logic              shr_ok;
    logic              take_ded;
    logic              take_shr;

    // Pool selection and the dedicated-first decision.
    always_comb begin
        vi         = (32'(req_vc) < NUM_VC) ? req_vc : '0;
        ti         = (req_type == 2'd3) ? 2'd0 : req_type;
        req_vc_rdy = vc_rdy[vi] && (32'(req_vc) < NUM_VC);
        req_ok     = req_valid && (req_type != 2'd3) && req_vc_rdy;
        ded_avail  = ded_cnt[vi][ti];
        shr_avail  = shr_cnt[ti];
        ded_ok     = ded_avail >= req_amt;
        shr_ok     = inf_q[ti] || (shr_avail >= req_amt);
        take_ded   = req_ok && ded_ok;
        take_shr   = req_ok && !ded_ok && shr_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt     <= 1'b0;
            gnt_ded <= 1'b0;
        end else begin
            gnt     <= take_ded || take_shr;
            gnt_ded <= take_ded;
        end
    end

    // A zero shared advertisement from channel 0 marks the type unlimited.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inf_q <= '0;
        end else begin
            for (int t = 0; t < NUM_TYPES; t++) begin
                if (vc_acc[0] && !adv_ded && (adv_type == 2'(t)) && (adv_value == '0))
                    inf_q[t] <= 1'b1;
            end
        end
    end

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        cpt_vc_init u_init (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv_hit  (adv_valid && (adv_vc == VC_W'(v))),
            .adv_type (adv_type),
            .adv_ded  (adv_ded),
            .allowed  ((v == 0) ? 1'b1 : vc_rdy[0]),
            .accept   (vc_acc[v]),
            .ready    (vc_rdy[v])
        );
        for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
            cpt_pool #(.CRED_W(CRED_W)) u_ded (
                .clk      (clk),
                .rst_n    (rst_n),
                .adv_en   (vc_acc[v] && adv_ded && (adv_type == 2'(t))),
                .adv_val  (adv_value),
                .take_en  (take_ded && (vi == VC_W'(v)) && (ti == 2'(t))),
                .take_amt (req_amt),
                .give_en  (ret_valid && ret_ded && (ret_vc == VC_W'(v)) && (ret_type == 2'(t))),
                .give_amt (ret_amt),
                .cnt      (ded_cnt[v][t]),
                .lim      (ded_lim[v][t])
            );
        end
    end

    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_shr
        cpt_pool #(.CRED_W(CRED_W)) u_shr (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv_en   ((|vc_acc) && !adv_ded && (adv_type == 2'(t))),
            .adv_val  (adv_value),
            .take_en  (take_shr && (ti == 2'(t)) && !inf_q[t]),
            .take_amt (req_amt),
            .give_en  (ret_valid && !ret_ded && (ret_type == 2'(t))),
            .give_amt (ret_amt),
            .cnt      (shr_cnt[t]),
            .lim      (shr_lim[t])
        );
    end

endmodule

// File: rtl/cpt_checker.sv
module cpt_checker
    import cpt_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int CRED_W = 10
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input logic                                          req_valid,
    input logic [CRED_W-1:0]                             req_amt,
    input logic                                          req_ok,
    input logic                                          req_vc_rdy,
    input logic                                          gnt,
    input logic                                          gnt_ded,
    input logic [CRED_W-1:0]                             ded_avail,
    input logic                                          shr_ok,
    input logic [NUM_VC-1:0]                             vc_rdy,
    input logic [NUM_TYPES-1:0]                          inf_q,
    input logic [NUM_TYPES-1:0][CRED_W-1:0]              shr_cnt,
    input logic [NUM_TYPES-1:0][CRED_W-1:0]              shr_lim,
    input logic [NUM_VC-1:0][NUM_TYPES-1:0][CRED_W-1:0]  ded_cnt,
    input logic [NUM_VC-1:0][NUM_TYPES-1:0][CRED_W-1:0]  ded_lim
);

    // R4
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> $past(req_valid && req_vc_rdy));

    // R5
    dedicated_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && !gnt_ded) |-> $past(ded_avail < req_amt));

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_ok) && !gnt) |-> $past((ded_avail < req_amt) && !shr_ok));

    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_t
        // R10
        shared_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            shr_cnt[t] <= shr_lim[t]);
        // R9
        inf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            inf_q[t] |=> inf_q[t]);
        for (genvar v = 0; v < NUM_VC; v++) begin : g_v
            // R10
            ded_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ded_cnt[v][t] <= ded_lim[v][t]);
        end
    end

    for (genvar k = 1; k < NUM_VC; k++) begin : g_k
        // R3
        vc0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(vc_rdy[k]) |-> vc_rdy[0]);
    end

endmodule

bind credit_pool_tracker cpt_checker #(.NUM_VC(NUM_VC), .CRED_W(CRED_W)) i_cpt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_amt    (req_amt),
    .req_ok     (req_ok),
    .req_vc_rdy (req_vc_rdy),
    .gnt        (gnt),
    .gnt_ded    (gnt_ded),
    .ded_avail  (ded_avail),
    .shr_ok     (shr_ok),
    .vc_rdy     (vc_rdy),
    .inf_q      (inf_q),
    .shr_cnt    (shr_cnt),
    .shr_lim    (shr_lim),
    .ded_cnt    (ded_cnt),
    .ded_lim    (ded_lim)
);

// File: tb/test_credit_pool_tracker.sv
`timescale 1ns/1ps
module test_credit_pool_tracker;

    localparam int NUM_VC = 4;
    localparam int CRED_W = 10;
    localparam int VC_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              adv_valid = 1'b0;
    logic [VC_W-1:0]   adv_vc = '0;
    logic [1:0]        adv_type = '0;
    logic              adv_ded = 1'b0;
    logic [CRED_W-1:0] adv_value = '0;
    logic              req_valid = 1'b0;
    logic [VC_W-1:0]   req_vc = '0;
    logic [1:0]        req_type = '0;
    logic [CRED_W-1:0] req_amt = '0;
    logic              ret_valid = 1'b0;
    logic [VC_W-1:0]   ret_vc = '0;
    logic [1:0]        ret_type = '0;
    logic              ret_ded = 1'b0;
    logic [CRED_W-1:0] ret_amt = '0;
    logic              gnt;
    logic              gnt_ded;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    credit_pool_tracker #(.NUM_VC(NUM_VC), .CRED_W(CRED_W)) i_credit_pool_tracker (
        .clk(clk), .rst_n(rst_n),
        .adv_valid(adv_valid), .adv_vc(adv_vc), .adv_type(adv_type),
        .adv_ded(adv_ded), .adv_value(adv_value),
        .req_valid(req_valid), .req_vc(req_vc), .req_type(req_type), .req_amt(req_amt),
        .ret_valid(ret_valid), .ret_vc(ret_vc), .ret_type(ret_type),
        .ret_ded(ret_ded), .ret_amt(ret_amt),
        .gnt(gnt), .gnt_ded(gnt_ded)
    );

    task automatic chk(string tag, logic exp_g, logic exp_d);
        checks++;
        if (gnt !== exp_g || (exp_g && gnt_ded !== exp_d)) begin
            errors++;
            $display("FAIL %s actual gnt=%0b gnt_ded=%0b expected gnt=%0b gnt_ded=%0b",
                     tag, gnt, gnt_ded, exp_g, exp_d);
        end
    endtask

    task automatic adv_one(int vc, int ty, bit ded, int val);
        @(negedge clk);
        adv_valid = 1'b1; adv_vc = VC_W'(vc); adv_type = 2'(ty);
        adv_ded = ded; adv_value = CRED_W'(val);
        @(negedge clk);
        adv_valid = 1'b0;
    endtask

    task automatic adv_all(int vc, int dp, int dn, int dc, int sp, int sn, int sc);
        adv_one(vc, 0, 1'b1, dp);
        adv_one(vc, 1, 1'b1, dn);
        adv_one(vc, 2, 1'b1, dc);
        adv_one(vc, 0, 1'b0, sp);
        adv_one(vc, 1, 1'b0, sn);
        adv_one(vc, 2, 1'b0, sc);
    endtask

    // Request sampled at the next rising edge; grant is visible just after it.
    task automatic req_one(int vc, int ty, int amt, logic exp_g, logic exp_d, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vc = VC_W'(vc); req_type = 2'(ty); req_amt = CRED_W'(amt);
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        chk(tag, exp_g, exp_d);
    endtask

    task automatic ret_one(int vc, int ty, bit ded, int amt);
        @(negedge clk);
        ret_valid = 1'b1; ret_vc = VC_W'(vc); ret_type = 2'(ty); ret_ded = ded; ret_amt = CRED_W'(amt);
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic t_reset();
        #2;
        chk("R1 reset state", 1'b0, 1'b0);
        req_one(0, 2, 0, 1'b0, 1'b0, "R1 no grant before any channel is ready");
    endtask

    task automatic t_init_order();
        // Channel 1 tries to initialize before channel 0: all ignored (R3).
        adv_all(1, 3, 3, 3, 3, 3, 3);
        // Out-of-order shared posted 7 for channel 0 is ignored (R2).
        adv_one(0, 0, 1'b0, 7);
        // R12: type 3 advertisement ignored.
        adv_one(0, 3, 1'b1, 5);
        adv_all(0, 2, 1, 1, 4, 3, 0);
        req_one(1, 2, 1, 1'b0, 1'b0, "R3 channel 1 ignored before channel 0 ready");
        req_one(3, 2, 1, 1'b0, 1'b0, "R4 uninitialized channel 3 never granted");
    endtask

    task automatic t_consume();
        req_one(0, 0, 2, 1'b1, 1'b1, "R5 dedicated first");
        req_one(0, 0, 1, 1'b1, 1'b0, "R6 shared fallback");
        req_one(0, 0, 4, 1'b0, 1'b0, "R2 stall proves out-of-order shared 7 ignored");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        req_valid = 1'b1; req_vc = 0; req_type = 0; req_amt = 1;
        ret_valid = 1'b1; ret_vc = 0; ret_type = 0; ret_ded = 1'b1; ret_amt = 1;
        @(posedge clk);
        #2;
        req_valid = 1'b0; ret_valid = 1'b0;
        chk("R11 same-cycle return not seen by request", 1'b1, 1'b0);
        req_one(0, 0, 1, 1'b1, 1'b1, "R11 return visible next cycle");
    endtask

    task automatic t_saturate();
        ret_one(0, 0, 1'b1, 5);
        req_one(0, 0, 3, 1'b0, 1'b0, "R10 dedicated return saturates at 2");
        req_one(0, 0, 2, 1'b1, 1'b1, "R10 dedicated refilled to limit");
        ret_one(0, 0, 1'b0, 10);
        req_one(0, 0, 4, 1'b1, 1'b0, "R10 shared refilled to limit 4");
        req_one(0, 0, 1, 1'b0, 1'b0, "R10 shared saturated not above 4");
    endtask

    task automatic t_infinite();
        req_one(0, 2, 1, 1'b1, 1'b1, "R9 completion dedicated first");
        req_one(0, 2, 50, 1'b1, 1'b0, "R9 infinite shared completion");
        req_one(0, 2, 50, 1'b1, 1'b0, "R9 infinite shared not depleted");
    endtask

    task automatic t_accumulate();
        adv_all(1, 0, 0, 0, 5, 0, 2);
        req_one(1, 0, 5, 1'b1, 1'b0, "R7 R8 channel 1 shared contribution added");
        req_one(1, 0, 1, 1'b0, 1'b0, "R7 shared posted exhausted");
        req_one(1, 1, 3, 1'b1, 1'b0, "R8 zero dedicated uses shared");
        req_one(1, 1, 1, 1'b0, 1'b0, "R7 zero contribution adds nothing");
        req_one(0, 1, 1, 1'b1, 1'b1, "R5 channel 0 non-posted dedicated");
        req_one(1, 2, 1, 1'b1, 1'b0, "R8 R9 completion via infinite shared");
    endtask

    task automatic t_late();
        adv_one(0, 0, 1'b1, 9);
        req_one(0, 0, 1, 1'b0, 1'b0, "R2 advertisement after ready ignored");
        req_one(0, 3, 0, 1'b0, 1'b0, "R12 type 3 request never granted");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_init_order();
        t_consume();
        t_same_cycle();
        t_saturate();
        t_infinite();
        t_accumulate();
        t_late();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule